// File: doc/BRIEF.md
# Conversion Result Holding Register with Coherent Byte Reads

This block keeps the most recent conversion result from an analog-to-digital converter. It presents that result to an 8-bit processor bus as two bytes. The low byte carries result bits 7..0. The high byte carries the remaining upper bits in its least significant positions, and every other bit of the high byte reads zero.

Because the processor reads the two bytes one after the other, a new result could otherwise land between the two reads. To prevent this, reading the low byte closes a lock. While the lock is closed, the converter cannot write either byte. Reading the high byte opens the lock again. A result that arrives while the lock is closed is thrown away, but it still produces a completion pulse for the flag and interrupt logic. A companion pulse marks the discarded result so that it can be observed. Bus address decoding and the converter itself sit outside this block.

Read data is combinational from the held registers and the read strobe of the current cycle. Completion and loss pulses appear one clock after the result-valid pulse, in the same cycle as the stored value changes.

Top module: `conv_result_hold`

## Requirements
- R1: A low-byte strobe returns result bits 7..0. A high-byte strobe returns result bits 9..8 in data bits 1..0, with data bits 7..2 at zero. With no strobe, the read data is zero.
- R2: A low-byte strobe (without a high-byte strobe) closes the lock. While the lock is closed, a result does not change either byte.
- R3: A high-byte strobe opens the lock, so that a result arriving in a later cycle is stored.
- R4: A result that is not stored still raises the completion pulse one cycle later. The loss pulse rises with it, and both bytes keep their old value.
- R5: A stored result appears in both bytes one cycle after its valid pulse. The completion pulse is high in that cycle and the loss pulse is low. Without a valid pulse, the completion pulse is low.
- R6: After reset, both bytes read zero, the lock is open, and neither pulse is high.
- R7: A high-byte strobe with the lock open returns the current high byte and leaves the lock open.
- R8: When a result arrives in the same cycle as a high-byte strobe, the read returns the old high byte and the new result is stored.
- R9: With both strobes in one cycle, the data port returns the low byte, the lock ends open, and a result in that cycle is stored.
- R10: A result that arrives in the same cycle as a lock-closing low-byte strobe is discarded, so that the next high-byte read matches the low byte already read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld_i | input | 1 | Converter result valid pulse |
| res_data_i | input | 10 | Converter result |
| rd_lo_i | input | 1 | Low-byte read strobe |
| rd_hi_i | input | 1 | High-byte read strobe |
| rd_data_o | output | 8 | Read data for the strobed byte |
| done_o | output | 1 | Completion pulse to the flag logic |
| lost_o | output | 1 | Pulse marking a discarded result |

## Verification
The bench first sweeps every 10-bit result value through a store, low-read, high-read sequence. A wrong byte split or a non-zero upper field would show up in that sweep.

It then runs every three-cycle sequence of valid pulse and the two strobes against an arithmetic model. This catches the collision cases:
- A design that stores a result arriving together with the lock-closing low read would hand out a torn pair.
- One that drops a result arriving with the unlocking high read would lose a value needlessly.
- One that suppresses the completion pulse for a discarded result would leave the flag logic waiting.
- One that locks on a lone high read would block the next result.

// File: rtl/conv_res_pkg.sv
package conv_res_pkg;
  typedef enum logic {
    LK_OPEN = 1'b0,
    LK_HELD = 1'b1
  } lock_state_e;

  typedef struct packed {
    logic store;
    logic drop;
  } wr_dec_t;
endpackage

// File: rtl/conv_lock_ctrl.sv
module conv_lock_ctrl
  import conv_res_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic res_vld_i,
  input  logic rd_lo_i,
  input  logic rd_hi_i,
  output logic wr_en_o,
  output logic locked_o,
  output logic done_o,
  output logic lost_o
);
  lock_state_e state_q, state_d;
  wr_dec_t     dec;
  logic        done_d, lost_d;

  always_comb begin
    state_d = state_q;
    if (rd_hi_i)      state_d = LK_OPEN;
    else if (rd_lo_i) state_d = LK_HELD;
    dec.store = res_vld_i & (rd_hi_i | ((state_q == LK_OPEN) & ~rd_lo_i));
    dec.drop  = res_vld_i & ~dec.store;
    done_d    = res_vld_i;
    lost_d    = dec.drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_OPEN;
      done_o  <= 1'b0;
      lost_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= done_d;
      lost_o  <= lost_d;
    end
  end

  assign wr_en_o  = dec.store;
  assign locked_o = (state_q == LK_HELD);
endmodule

// File: rtl/conv_byte_store.sv
module conv_byte_store #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [RES_W-1:0] wr_data_i,
  output logic [RES_W-1:0] q_o
);
  logic [RES_W-1:0] q_d;

  always_comb begin
    q_d = q_o;
    if (wr_en_i) q_d = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/conv_rd_mux.sv
module conv_rd_mux #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic [RES_W-1:0]  q_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] lo_byte, hi_byte;

  assign lo_byte = q_i[BYTE_W-1:0];

  for (genvar i = 0; i < BYTE_W; i++) begin : g_hi
    if (BYTE_W + i < RES_W) begin : g_bit
      assign hi_byte[i] = q_i[BYTE_W+i];
    end else begin : g_zero
      assign hi_byte[i] = 1'b0;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_lo_i)      rd_data_o = lo_byte;
    else if (rd_hi_i) rd_data_o = hi_byte;
  end
endmodule

// File: rtl/conv_result_hold.sv
module conv_result_hold #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld_i,
  input  logic [RES_W-1:0]  res_data_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              lost_o
);
  logic             wr_en;
  logic             locked;
  logic [RES_W-1:0] store_q;

  conv_lock_ctrl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_vld_i(res_vld_i),
    .rd_lo_i  (rd_lo_i),
    .rd_hi_i  (rd_hi_i),
    .wr_en_o  (wr_en),
    .locked_o (locked),
    .done_o   (done_o),
    .lost_o   (lost_o)
  );

  conv_byte_store #(.RES_W(RES_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en),
    .wr_data_i(res_data_i),
    .q_o      (store_q)
  );

  conv_rd_mux #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_mux (
    .q_i      (store_q),
    .rd_lo_i  (rd_lo_i),
    .rd_hi_i  (rd_hi_i),
    .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/conv_result_hold_chk.sv
module conv_result_hold_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_vld_i,
  input logic [RES_W-1:0]  res_data_i,
  input logic              rd_lo_i,
  input logic              rd_hi_i,
  input logic [BYTE_W-1:0] rd_data_o,
  input logic              done_o,
  input logic              lost_o,
  input logic              locked,
  input logic [RES_W-1:0]  store_q
);
  AST_FROZEN_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rd_hi_i) |=> $stable(store_q)); // R2
  AST_LO_CLOSES_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo_i && !rd_hi_i) |=> locked); // R2
  AST_HI_OPENS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi_i |=> !locked); // R3
  AST_DROP_STILL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && locked && !rd_hi_i) |=> (done_o && lost_o)); // R4
  AST_LOST_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> done_o); // R4
  AST_DONE_AFTER_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_i |=> done_o); // R5
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld_i |=> !done_o); // R5
  AST_HI_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi_i && !rd_lo_i) |-> (rd_data_o[BYTE_W-1:RES_W-BYTE_W] == '0)); // R1
  AST_UNLOCK_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld_i && rd_hi_i) |=> (store_q == $past(res_data_i))); // R8
endmodule

bind conv_result_hold conv_result_hold_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_vld_i (res_vld_i),
  .res_data_i(res_data_i),
  .rd_lo_i   (rd_lo_i),
  .rd_hi_i   (rd_hi_i),
  .rd_data_o (rd_data_o),
  .done_o    (done_o),
  .lost_o    (lost_o),
  .locked    (locked),
  .store_q   (store_q)
);

// File: tb/sim_conv_result_hold.sv
`timescale 1ns/1ps
module sim_conv_result_hold;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_vld_i;
  logic [9:0] res_data_i;
  logic       rd_lo_i;
  logic       rd_hi_i;
  logic [7:0] rd_data_o;
  logic       done_o;
  logic       lost_o;

  int   checks = 0;
  int   failures = 0;
  bit   finished = 1'b0;
  logic [9:0] m_data;
  logic       m_lock;
  logic [9:0] seq_val;

  always #2.5 clk = ~clk;

  conv_result_hold u0 (
    .clk(clk), .rst_n(rst_n), .res_vld_i(res_vld_i), .res_data_i(res_data_i),
    .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .rd_data_o(rd_data_o),
    .done_o(done_o), .lost_o(lost_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, check read data, step, check pulses.
  task automatic cyc(input logic v, input logic [9:0] d, input logic lo, input logic hi);
    logic [7:0] exp_rd;
    logic       acc;
    string      tag;
    res_vld_i = v; res_data_i = d; rd_lo_i = lo; rd_hi_i = hi;
    acc = v & (hi | (~m_lock & ~lo));
    if (v && lo && hi)              tag = "R9";
    else if (v && hi && m_lock)     tag = "R8";
    else if (v && lo && !m_lock)    tag = "R10";
    else if (v && !acc)             tag = "R4";
    else if (v)                     tag = "R5";
    else if (lo && hi)              tag = "R9";
    else if (hi && !m_lock)         tag = "R7";
    else if (hi)                    tag = "R3";
    else if (lo)                    tag = "R2";
    else                            tag = "R1";
    if (lo)      exp_rd = m_data[7:0];
    else if (hi) exp_rd = {6'b0, m_data[9:8]};
    else         exp_rd = 8'h00;
    #1;
    chk(tag, "rd_data(R1)", int'(rd_data_o), int'(exp_rd));
    @(posedge clk);
    @(negedge clk);
    chk(tag, "done", int'(done_o), int'(v));
    chk(tag, "lost", int'(lost_o), int'(v & ~acc));
    if (acc) m_data = d;
    if (hi)      m_lock = 1'b0;
    else if (lo) m_lock = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; res_vld_i = 1'b0; res_data_i = '0; rd_lo_i = 1'b0; rd_hi_i = 1'b0;
    m_data = '0; m_lock = 1'b0; seq_val = 10'h155;
    #12;
    @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state seen at ports
    chk("R6", "done", int'(done_o), 0);
    chk("R6", "lost", int'(lost_o), 0);
    rd_lo_i = 1'b1; #1;
    chk("R6", "lo byte", int'(rd_data_o), 0);
    rd_lo_i = 1'b0; rd_hi_i = 1'b1; #1;
    chk("R6", "hi byte", int'(rd_data_o), 0);
    rd_hi_i = 1'b0;
    // R6: lock open after reset, a result is stored
    cyc(1'b1, 10'h3A5, 1'b0, 1'b0);
    cyc(1'b0, 10'h000, 1'b1, 1'b0);
    cyc(1'b0, 10'h000, 1'b0, 1'b1);
    // Full sweep of result values through store / low read / high read (R1, R5)
    for (int v = 0; v < 1024; v++) begin
      cyc(1'b1, 10'(v), 1'b0, 1'b0);
      cyc(1'b0, 10'(v ^ 10'h3FF), 1'b1, 1'b0);
      cyc(1'b0, 10'h000, 1'b0, 1'b1);
    end
    // Every three-cycle sequence of {valid, low, high}: R2 R3 R4 R7 R8 R9 R10
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        for (int c = 0; c < 8; c++) begin
          cyc(a[2], seq_val, a[1], a[0]); seq_val = seq_val * 10'd37 + 10'd11;
          cyc(b[2], seq_val, b[1], b[0]); seq_val = seq_val * 10'd37 + 10'd11;
          cyc(c[2], seq_val, c[1], c[0]); seq_val = seq_val * 10'd37 + 10'd11;
        end
      end
    end
    cyc(1'b0, 10'h000, 1'b0, 1'b1);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule